// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block decides which of the highest-priority CPU exceptions is taken and drives the state changes that enter its handler. When it is idle, it samples four request lines together with the current program counter, status word, vector base and stack pointer. A debug stop has the highest priority and cannot be masked. For a debug stop, the block copies the status word and program counter into two dedicated debug return registers. It then loads a fixed debug entry address and raises the debug and exception-mask flags in the status word.

Every other accepted fault takes the stack path. The block pushes the faulting program counter and then the old status word through a single-word write port. Each write waits for its acknowledge. The block then updates the program counter, status word and stack pointer together in one commit cycle. A fault that arrives while the exception-mask bit is already set becomes the unrecoverable exception.

The sequencer has five states:

- **IDLE**: samples the requests and arbitrates between them.
- **DBG**: the single debug commit cycle.
- **PUSH_PC**: the first stack write.
- **PUSH_SR**: the second stack write.
- **COMMIT**: loads the new program counter, status word and stack pointer.

The transitions are:

- IDLE→DBG when a debug stop is accepted.
- IDLE→PUSH_PC when a fault is accepted.
- PUSH_PC→PUSH_SR on an acknowledge.
- PUSH_SR→COMMIT on an acknowledge.
- DBG→IDLE and COMMIT→IDLE unconditionally.

Top module: `exc_entry_seq`

## Requirements
- R1: A debug stop request seen in IDLE is always taken, whatever the status bits and whatever other requests are active at the same time. No memory write is made for it.
- R2: On debug entry, the debug return-status and return-address outputs take the sampled status word and program counter from the cycle after acceptance onward. In that same cycle, `pc_load` is high with `pc_next` = 0x8000_0000.
- R3: The debug status word is the sampled status with these changes: bits 24:22 set to 3'b110, and bits 27 (debug), 26 (debug mode), 21 (exception mask) and 16 (global interrupt mask) set. All other bits are unchanged.
- R4: If bit 21 of the sampled status is set, no debug stop is present, and any of bus error, multi-hit or generic request is present, the unrecoverable exception is taken. Its vector is the vector base OR 0x00.
- R5: A multiple-region protection hit with bit 21 clear vectors to the vector base OR 0x04. It wins over a bus error raised in the same cycle.
- R6: A data-bus error with bit 21 clear vectors to the vector base OR 0x08.
- R7: For every stack-path entry, the first write puts the sampled program counter at SP-4 and the second puts the sampled status word at SP-8. Each write holds its address and data until it is acknowledged.
- R8: The cycle after the second acknowledge is the commit cycle. In it, `pc_load`, `sr_load` and `sp_load` are all high, `sp_next` = SP-8, and the status word is the sampled one with bits 24:22 = 3'b110 and bits 21 and 16 set. All other bits, including 27 and 26, are unchanged.
- R9: `busy` is high from the cycle after acceptance through the last commit cycle. Requests that arrive while `busy` is high do not change the sequence in progress.
- R10: A generic request with bit 21 clear and no other request present is ignored, and `busy` stays low.
- R11: After reset, `busy`, all load strobes and `mem_wr_valid` are low, and both debug return registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_stop_req | input | 1 | Debug stop request |
| bus_err_req | input | 1 | Data-bus error flag |
| mpu_multi_req | input | 1 | Access matched several protection regions |
| gen_exc_req | input | 1 | Generic exception request (escalation only) |
| pc_in | input | XLEN | Current program counter |
| sr_in | input | XLEN | Current status word |
| evba_in | input | XLEN | Exception vector base |
| sp_in | input | XLEN | Current system stack pointer |
| mem_wr_ack | input | 1 | Write port acknowledge |
| busy | output | 1 | Entry sequence in progress |
| mem_wr_valid | output | 1 | Stack write request |
| mem_wr_addr | output | XLEN | Stack write address |
| mem_wr_data | output | XLEN | Stack write data |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | XLEN | New program counter |
| sr_load | output | 1 | Load `sr_next` into the status word |
| sr_next | output | XLEN | New status word |
| sp_load | output | 1 | Load `sp_next` into the stack pointer |
| sp_next | output | XLEN | New stack pointer |
| dbg_rsr | output | XLEN | Debug return status |
| dbg_rar | output | XLEN | Debug return address |

## Verification
The bench builds the block with its defaults: a 32-bit word, debug entry 0x8000_0000, and vector offsets 0x00, 0x04 and 0x08. With a 32-bit word, the stack frame is exactly 8 bytes and the status-bit positions sit inside the word. The acknowledge delay is varied from zero to several cycles, which brings write-hold and back-to-back acknowledge behaviour within reach. The scenarios cover each exception kind with the mask bit clear and set, simultaneous requests, and a debug pulse injected during a push.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // status word bit positions decoded by the surrounding core
    localparam int SR_GM   = 16;
    localparam int SR_EM   = 21;
    localparam int SR_M_LO = 22;
    localparam int SR_DM   = 26;
    localparam int SR_D    = 27;

    localparam logic [2:0] MODE_EXC = 3'b110;

    typedef enum logic [1:0] {
        K_DEBUG,
        K_UNREC,
        K_MPU,
        K_BUSERR
    } exc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DBG,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_COMMIT
    } seq_state_e;

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_entry_pkg::*;
(
    input  logic      dbg_req,
    input  logic      bus_req,
    input  logic      mpu_req,
    input  logic      gen_req,
    input  logic      mask_em,
    output logic      take,
    output exc_kind_e kind
);

    logic any_fault;

    assign any_fault = bus_req | mpu_req | gen_req;

    always_comb begin
        take = 1'b1;
        kind = K_DEBUG;
        if (dbg_req) begin
            kind = K_DEBUG;
        end else if (mask_em && any_fault) begin
            kind = K_UNREC;
        end else if (mpu_req) begin
            kind = K_MPU;
        end else if (bus_req) begin
            kind = K_BUSERR;
        end else begin
            take = 1'b0;
        end
    end

endmodule

// File: rtl/exc_sr_shaper.sv
module exc_sr_shaper
    import exc_entry_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] sr_old,
    input  logic         dbg_entry,
    output logic [W-1:0] sr_new
);

    always_comb begin
        sr_new                   = sr_old;
        sr_new[SR_M_LO +: 3]     = MODE_EXC;
        sr_new[SR_EM]            = 1'b1;
        sr_new[SR_GM]            = 1'b1;
        if (dbg_entry) begin
            sr_new[SR_D]  = 1'b1;
            sr_new[SR_DM] = 1'b1;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int               XLEN         = 32,
    parameter logic [XLEN-1:0]  DBG_ENTRY_PC = 32'h8000_0000,
    parameter logic [XLEN-1:0]  OFS_UNREC    = 32'h0000_0000,
    parameter logic [XLEN-1:0]  OFS_MPU      = 32'h0000_0004,
    parameter logic [XLEN-1:0]  OFS_BUSERR   = 32'h0000_0008
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_stop_req,
    input  logic            bus_err_req,
    input  logic            mpu_multi_req,
    input  logic            gen_exc_req,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] evba_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic            mem_wr_ack,
    output logic            busy,
    output logic            mem_wr_valid,
    output logic [XLEN-1:0] mem_wr_addr,
    output logic [XLEN-1:0] mem_wr_data,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_next,
    output logic            sr_load,
    output logic [XLEN-1:0] sr_next,
    output logic            sp_load,
    output logic [XLEN-1:0] sp_next,
    output logic [XLEN-1:0] dbg_rsr,
    output logic [XLEN-1:0] dbg_rar
);

    localparam logic [XLEN-1:0] WORD_BYTES  = XLEN'(XLEN / 8);
    localparam logic [XLEN-1:0] FRAME_BYTES = XLEN'(2 * (XLEN / 8));

    seq_state_e      state, state_nxt;
    exc_kind_e       pick_kind, kind_q;
    logic            pick_take;
    logic [XLEN-1:0] pc_q, sr_q, evba_q, sp_q;
    logic [XLEN-1:0] dbg_rsr_q, dbg_rar_q;
    logic [XLEN-1:0] sr_shaped;
    logic [XLEN-1:0] vec_ofs;

    exc_prio_pick u_pick (
        .dbg_req (dbg_stop_req),
        .bus_req (bus_err_req),
        .mpu_req (mpu_multi_req),
        .gen_req (gen_exc_req),
        .mask_em (sr_in[SR_EM]),
        .take    (pick_take),
        .kind    (pick_kind)
    );

    exc_sr_shaper #(.W(XLEN)) u_shape (
        .sr_old    (sr_q),
        .dbg_entry (kind_q == K_DEBUG),
        .sr_new    (sr_shaped)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (pick_take)
                    state_nxt = (pick_kind == K_DEBUG) ? ST_DBG : ST_PUSH_PC;
            end
            ST_DBG:     state_nxt = ST_IDLE;
            ST_PUSH_PC: if (mem_wr_ack) state_nxt = ST_PUSH_SR;
            ST_PUSH_SR: if (mem_wr_ack) state_nxt = ST_COMMIT;
            ST_COMMIT:  state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // context capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= K_DEBUG;
            pc_q      <= '0;
            sr_q      <= '0;
            evba_q    <= '0;
            sp_q      <= '0;
            dbg_rsr_q <= '0;
            dbg_rar_q <= '0;
        end else if (state == ST_IDLE && pick_take) begin
            kind_q <= pick_kind;
            pc_q   <= pc_in;
            sr_q   <= sr_in;
            evba_q <= evba_in;
            sp_q   <= sp_in;
            if (pick_kind == K_DEBUG) begin
                dbg_rsr_q <= sr_in;
                dbg_rar_q <= pc_in;
            end
        end
    end

    always_comb begin
        case (kind_q)
            K_UNREC:  vec_ofs = OFS_UNREC;
            K_MPU:    vec_ofs = OFS_MPU;
            K_BUSERR: vec_ofs = OFS_BUSERR;
            default:  vec_ofs = '0;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        mem_wr_valid = 1'b0;
        mem_wr_addr  = '0;
        mem_wr_data  = '0;
        pc_load      = 1'b0;
        pc_next      = '0;
        sr_load      = 1'b0;
        sr_next      = '0;
        sp_load      = 1'b0;
        sp_next      = '0;
        unique case (state)
            ST_IDLE: ;
            ST_DBG: begin
                pc_load = 1'b1;
                pc_next = DBG_ENTRY_PC;
                sr_load = 1'b1;
                sr_next = sr_shaped;
            end
            ST_PUSH_PC: begin
                mem_wr_valid = 1'b1;
                mem_wr_addr  = sp_q - WORD_BYTES;
                mem_wr_data  = pc_q;
            end
            ST_PUSH_SR: begin
                mem_wr_valid = 1'b1;
                mem_wr_addr  = sp_q - FRAME_BYTES;
                mem_wr_data  = sr_q;
            end
            ST_COMMIT: begin
                pc_load = 1'b1;
                pc_next = evba_q | vec_ofs;
                sr_load = 1'b1;
                sr_next = sr_shaped;
                sp_load = 1'b1;
                sp_next = sp_q - FRAME_BYTES;
            end
            default: ;
        endcase
    end

    assign dbg_rsr = dbg_rsr_q;
    assign dbg_rar = dbg_rar_q;

    // R1: a debug stop in idle commits to the fixed entry next cycle, with no write
    p_dbg_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dbg_stop_req) |=> (pc_load && pc_next == DBG_ENTRY_PC && !mem_wr_valid));

    // R4: masked fault escalates into the stack path, first word is the sampled PC
    p_escalate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dbg_stop_req && sr_in[SR_EM] && (bus_err_req || mpu_multi_req || gen_exc_req))
        |=> (mem_wr_valid && mem_wr_data == $past(pc_in)));

    // R7: a pending write holds address and data
    p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ack) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R8: every status load carries the exception mode and both mask bits
    p_mode_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> (sr_next[SR_EM] && sr_next[SR_GM] && sr_next[SR_M_LO +: 3] == MODE_EXC));

    // R10: an unmasked generic request alone starts nothing
    p_gen_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dbg_stop_req && !bus_err_req && !mpu_multi_req && !sr_in[SR_EM]) |=> !busy);

endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_stop_req = 1'b0, bus_err_req = 1'b0, mpu_multi_req = 1'b0, gen_exc_req = 1'b0;
    logic [31:0] pc_in = '0, sr_in = '0, evba_in = '0, sp_in = '0;
    logic        mem_wr_ack = 1'b0;
    logic        busy, mem_wr_valid, pc_load, sr_load, sp_load;
    logic [31:0] mem_wr_addr, mem_wr_data, pc_next, sr_next, sp_next, dbg_rsr, dbg_rar;

    always #2 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .dbg_stop_req(dbg_stop_req), .bus_err_req(bus_err_req),
        .mpu_multi_req(mpu_multi_req), .gen_exc_req(gen_exc_req),
        .pc_in(pc_in), .sr_in(sr_in), .evba_in(evba_in), .sp_in(sp_in),
        .mem_wr_ack(mem_wr_ack), .busy(busy),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .pc_load(pc_load), .pc_next(pc_next), .sr_load(sr_load), .sr_next(sr_next),
        .sp_load(sp_load), .sp_next(sp_next), .dbg_rsr(dbg_rsr), .dbg_rar(dbg_rar)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 debug commit, 2 first push, 3 second push, 4 commit
    int          m_phase = 0, m_kind = 0;
    logic [31:0] m_pc, m_sr, m_sp, m_ev, m_rsr = '0, m_rar = '0;

    function automatic logic [31:0] exp_sr(input logic [31:0] s, input bit dbg);
        logic [31:0] r;
        r = (s & ~(32'h7 << 22)) | (32'h6 << 22) | (32'h1 << 21) | (32'h1 << 16);
        if (dbg) r = r | (32'h1 << 27) | (32'h1 << 26);
        return r;
    endfunction

    function automatic logic [31:0] exp_vec(input int k);
        case (k)
            1: return 32'h0;
            2: return 32'h4;
            default: return 32'h8;
        endcase
    endfunction

    function automatic string vec_tag(input int k);
        case (k)
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_rsr = '0; m_rar = '0;
        end else begin
            case (m_phase)
                0: begin
                    m_pc = pc_in; m_sr = sr_in; m_sp = sp_in; m_ev = evba_in;
                    if (dbg_stop_req) begin
                        m_kind = 0; m_phase = 1; m_rsr = sr_in; m_rar = pc_in;
                    end else if (sr_in[21] && (bus_err_req || mpu_multi_req || gen_exc_req)) begin
                        m_kind = 1; m_phase = 2;
                    end else if (mpu_multi_req) begin
                        m_kind = 2; m_phase = 2;
                    end else if (bus_err_req) begin
                        m_kind = 3; m_phase = 2;
                    end
                end
                1: m_phase = 0;
                2: if (mem_wr_ack) m_phase = 3;
                3: if (mem_wr_ack) m_phase = 4;
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_phase != 0), "R9 busy", {31'b0, busy}, {31'b0, m_phase != 0});
            chk(mem_wr_valid == (m_phase == 2 || m_phase == 3), "R7 valid",
                {31'b0, mem_wr_valid}, {31'b0, m_phase == 2 || m_phase == 3});
            if (m_phase == 2) begin
                chk(mem_wr_addr == m_sp - 32'd4, "R7 addr1", mem_wr_addr, m_sp - 32'd4);
                chk(mem_wr_data == m_pc, "R7 data1", mem_wr_data, m_pc);
            end
            if (m_phase == 3) begin
                chk(mem_wr_addr == m_sp - 32'd8, "R7 addr2", mem_wr_addr, m_sp - 32'd8);
                chk(mem_wr_data == m_sr, "R7 data2", mem_wr_data, m_sr);
            end
            chk(pc_load == (m_phase == 1 || m_phase == 4), "R8 pc_load",
                {31'b0, pc_load}, {31'b0, m_phase == 1 || m_phase == 4});
            chk(sp_load == (m_phase == 4), "R8 sp_load", {31'b0, sp_load}, {31'b0, m_phase == 4});
            if (m_phase == 1) begin
                chk(pc_next == 32'h8000_0000, "R2 entry", pc_next, 32'h8000_0000);
                chk(sr_load && sr_next == exp_sr(m_sr, 1), "R3 sr", sr_next, exp_sr(m_sr, 1));
            end
            if (m_phase == 4) begin
                chk(pc_next == (m_ev | exp_vec(m_kind)), vec_tag(m_kind), pc_next, m_ev | exp_vec(m_kind));
                chk(sr_load && sr_next == exp_sr(m_sr, 0), "R8 sr", sr_next, exp_sr(m_sr, 0));
                chk(sp_next == m_sp - 32'd8, "R8 sp", sp_next, m_sp - 32'd8);
            end
            chk(dbg_rsr == m_rsr, "R2 rsr", dbg_rsr, m_rsr);
            chk(dbg_rar == m_rar, "R2 rar", dbg_rar, m_rar);
        end
    end

    // drive one request pattern, then serve the write port until the sequence ends
    task automatic fire(input bit d, input bit b, input bit m, input bit g,
                        input logic [31:0] sr, input logic [31:0] pc,
                        input logic [31:0] sp, input logic [31:0] ev,
                        input int dly, input bit inject);
        int cnt = 0;
        int it = 0;
        @(negedge clk);
        dbg_stop_req = d; bus_err_req = b; mpu_multi_req = m; gen_exc_req = g;
        sr_in = sr; pc_in = pc; sp_in = sp; evba_in = ev;
        @(negedge clk);
        dbg_stop_req = 1'b0; bus_err_req = 1'b0; mpu_multi_req = 1'b0; gen_exc_req = 1'b0;
        while (busy) begin
            dbg_stop_req = (inject && it == 0);
            if (mem_wr_valid) begin
                if (cnt >= dly) begin mem_wr_ack = 1'b1; cnt = 0; end
                else begin mem_wr_ack = 1'b0; cnt++; end
            end else mem_wr_ack = 1'b0;
            it++;
            @(negedge clk);
            if (inject && it == 1)
                chk(mem_wr_valid && !pc_load, "R9 inject", {31'b0, mem_wr_valid}, 32'd1);
        end
        mem_wr_ack = 1'b0;
        dbg_stop_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !pc_load && !sr_load && !sp_load && !mem_wr_valid, "R11 strobes",
            {27'b0, busy, pc_load, sr_load, sp_load, mem_wr_valid}, 32'd0);
        chk(dbg_rsr == 32'd0 && dbg_rar == 32'd0, "R11 dbg regs", dbg_rsr | dbg_rar, 32'd0);
        rst_n = 1'b1;

        // debug with a plain status word
        fire(1, 0, 0, 0, 32'h0000_0003, 32'h0000_1234, 32'h2000_0100, 32'h4000_0000, 0, 0);
        // debug wins over a masked bus error (R1)
        @(negedge clk);
        dbg_stop_req = 1; bus_err_req = 1; sr_in = 32'h0020_0000; pc_in = 32'h0000_5550;
        @(negedge clk);
        dbg_stop_req = 0; bus_err_req = 0;
        chk(pc_load && !mem_wr_valid, "R1 debug first", {30'b0, pc_load, mem_wr_valid}, 32'd2);
        @(negedge clk);
        // multi-hit, immediate ack
        fire(0, 0, 1, 0, 32'h0001_0005, 32'h0000_2000, 32'h2000_0200, 32'h4000_1000, 0, 0);
        // bus error, slow ack
        fire(0, 1, 0, 0, 32'h0C00_00F0, 32'h0000_3000, 32'h2000_0300, 32'h4000_2000, 3, 0);
        // multi-hit and bus error together (R5)
        fire(0, 1, 1, 0, 32'h0000_0000, 32'h0000_3100, 32'h2000_0400, 32'h4000_3000, 1, 0);
        // masked bus error, masked generic, masked multi-hit (R4)
        fire(0, 1, 0, 0, 32'h0020_0001, 32'h0000_4000, 32'h2000_0500, 32'h4000_4000, 0, 0);
        fire(0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0000_4100, 32'h2000_0600, 32'h4000_5000, 2, 0);
        fire(0, 0, 1, 0, 32'h0020_0000, 32'h0000_4200, 32'h2000_0700, 32'h4000_6000, 1, 0);
        // unmasked generic alone (R10)
        fire(0, 0, 0, 1, 32'h0000_0000, 32'h0000_5000, 32'h2000_0800, 32'h4000_7000, 0, 0);
        chk(!busy && !mem_wr_valid, "R10 ignored", {31'b0, busy}, 32'd0);
        // debug pulse during a push is ignored (R9)
        fire(0, 1, 0, 0, 32'h0000_0010, 32'h0000_6000, 32'h2000_0900, 32'h4000_8000, 2, 1);
        repeat (3) @(negedge clk);
        // debug again, regs refresh
        fire(1, 0, 0, 0, 32'h0020_0000, 32'h0000_7000, 32'h2000_0A00, 32'h4000_9000, 0, 0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected below %0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule